// File: doc/BRIEF.md
# I2C Slave Range Address Matcher

This block works next to an I2C slave shift engine. Once the engine has shifted in the full address byte, it pulses a one-cycle strobe. The matcher then decides whether the 7-bit calling address selects this device under a windowed rule. Two programmable address registers set the window: a lower bound and an upper value. The upper value also acts as an exact-match address. A separate enable register switches the rule on and off.

When the rule hits, the matcher does three things. It sets a sticky "addressed by range" flag. It captures the read/write bit, which is the LSB of the address byte. It raises a one-cycle match event for the interrupt logic. Only a write to the control register clears the sticky flag. A miss leaves it unchanged. The compare always uses the register values that held before the strobe's clock edge.

Top module: `i2c_rng_addr_match`

## Requirements
- R1: After reset, `rng_flag`, `slv_dir` and `match_pulse` are 0. The lower-bound, upper and enable registers also reset to 0.
- R2: While the enable register holds 0, no strobe sets `rng_flag` or raises `match_pulse`, even for an address inside the window.
- R3: With enable at 1, a nonzero calling address (`addr_byte[7:1]`) equal to the upper register produces a hit. This also holds when the upper value is not above the lower bound.
- R4: With enable at 1, an address strictly greater than the lower bound and at most the upper register produces a hit. An address equal to the lower bound, or above the upper value, does not.
- R5: A calling address of 0 never produces a hit, whatever the register contents.
- R6: A cycle with `ctrl_wr` high clears `rng_flag` on the next edge, whatever `cfg_wdata` holds.
- R7: When a hitting strobe and `ctrl_wr` arrive in the same cycle, `rng_flag` is 1 afterwards.
- R8: On a hit, `slv_dir` takes `addr_byte[0]` (0 = master writes and the slave receives; 1 = master reads and the slave transmits). A missed strobe leaves `slv_dir` unchanged.
- R9: `match_pulse` is high for exactly the one cycle after the edge that sampled a hitting strobe, and stays low for misses.
- R10: A missed strobe does not clear a set `rng_flag`.
- R11: `lo_wr` loads `cfg_wdata[6:0]` into the lower bound, `hi_wr` loads `cfg_wdata[6:0]` into the upper register, and `en_wr` loads `cfg_wdata[0]` into the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wdata | input | 8 | Write data for the configuration registers |
| lo_wr | input | 1 | Load the lower-bound register |
| hi_wr | input | 1 | Load the upper/exact register |
| en_wr | input | 1 | Load the range enable |
| ctrl_wr | input | 1 | Control-register write; clears the flag |
| addr_byte | input | 8 | Received address byte: {address[6:0], R/W} |
| addr_stb | input | 1 | One-cycle strobe when the address byte is complete |
| rng_flag | output | 1 | Sticky addressed-by-range flag |
| slv_dir | output | 1 | Captured R/W direction |
| match_pulse | output | 1 | One-cycle match event |

## Verification
The assertions check four things on every cycle:
- the flag rises only when enable was set;
- a match pulse always follows a strobe and carries the captured direction;
- a general-call address never yields a pulse;
- a clear without a hit empties the flag, and a collision keeps it set.

Only the bench scenarios can show the edges of the window. These are the excluded lower bound, the included upper value, and an exact match with an inverted window. The scenarios also show that the flag and the direction survive missed strobes, and that each register load reaches the compare.

// File: rtl/i2c_rng_pkg.sv
package i2c_rng_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;
  typedef logic [ADDR_W-1:0] addr_t;

  // exact hit on the upper register, general call excluded
  function automatic logic exact_hit(addr_t a, addr_t hi);
    return (a != '0) && (a == hi);
  endfunction

  // open below, closed above
  function automatic logic window_hit(addr_t a, addr_t lo, addr_t hi);
    return (a > lo) && (a <= hi);
  endfunction

  function automatic logic range_hit(logic en, addr_t a, addr_t lo, addr_t hi);
    return en && (a != '0) && (exact_hit(a, hi) || window_hit(a, lo, hi));
  endfunction
endpackage

// File: rtl/i2c_rng_cfg.sv
module i2c_rng_cfg
  import i2c_rng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              en_wr,
  output addr_t             lo_q,
  output addr_t             hi_q,
  output logic              en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      en_q <= 1'b0;
    end else begin
      if (lo_wr) lo_q <= wdata[ADDR_W-1:0];
      if (hi_wr) hi_q <= wdata[ADDR_W-1:0];
      if (en_wr) en_q <= wdata[0];
    end
  end

  assert_en_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(wdata[0])));
  assert_lo_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (lo_q == $past(wdata[ADDR_W-1:0])));
endmodule

// File: rtl/i2c_rng_cmp.sv
module i2c_rng_cmp
  import i2c_rng_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  addr_t call_addr,
  input  addr_t lo,
  input  addr_t hi,
  output logic  gen_call,
  output logic  hit
);
  assign gen_call = (call_addr == '0);
  assign hit      = range_hit(en, call_addr, lo, hi);

  assert_gencall_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> !hit);
  assert_off_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !hit);
endmodule

// File: rtl/i2c_rng_status.sv
module i2c_rng_status (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic hit,
  input  logic rw,
  input  logic clr,
  output logic flag,
  output logic dir,
  output logic pulse
);
  logic take;
  assign take = stb & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      dir   <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= take;
      if (take) begin
        flag <= 1'b1;
        dir  <= rw;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  assert_pulse_after_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(stb));
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !take) |=> !pulse);
  assert_flag_rise_has_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> pulse);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !take) |=> !flag);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && take) |=> flag);
  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(dir));
  assert_dir_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (dir == $past(rw)));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/i2c_rng_addr_match.sv
module i2c_rng_addr_match
  import i2c_rng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              en_wr,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              addr_stb,
  output logic              rng_flag,
  output logic              slv_dir,
  output logic              match_pulse
);
  addr_t lo_q, hi_q, call_addr;
  logic  en_q, gen_call, hit_now, rw_bit;

  assign call_addr = addr_byte[BYTE_W-1:1];
  assign rw_bit    = addr_byte[0];

  i2c_rng_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wdata(cfg_wdata),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .en_wr(en_wr),
    .lo_q(lo_q), .hi_q(hi_q), .en_q(en_q)
  );

  i2c_rng_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .en(en_q), .call_addr(call_addr),
    .lo(lo_q), .hi(hi_q), .gen_call(gen_call), .hit(hit_now)
  );

  i2c_rng_status u_st (
    .clk(clk), .rst_n(rst_n), .stb(addr_stb), .hit(hit_now), .rw(rw_bit),
    .clr(ctrl_wr), .flag(rng_flag), .dir(slv_dir), .pulse(match_pulse)
  );

  assert_no_set_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && !en_q) |=> !match_pulse);
  assert_gencall_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && gen_call) |=> !match_pulse);
endmodule

// File: tb/i2c_rng_addr_match_tb.sv
module i2c_rng_addr_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       lo_wr = 0, hi_wr = 0, en_wr = 0, ctrl_wr = 0;
  logic [7:0] addr_byte = '0;
  logic       addr_stb = 0;
  logic       rng_flag, slv_dir, match_pulse;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;
  logic [6:0] m_lo = 0, m_hi = 0;
  logic       m_en = 0;

  always #2 clk = ~clk;

  i2c_rng_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata), .lo_wr(lo_wr),
    .hi_wr(hi_wr), .en_wr(en_wr), .ctrl_wr(ctrl_wr), .addr_byte(addr_byte),
    .addr_stb(addr_stb), .rng_flag(rng_flag), .slv_dir(slv_dir),
    .match_pulse(match_pulse)
  );

  // expected hit, written from the requirements
  function automatic logic model(logic [6:0] a);
    if (!m_en || a == 7'd0) return 1'b0;
    if (a == m_hi) return 1'b1;
    return (a >= m_lo + 8'd1) && !(a > m_hi);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    cfg_wdata = d;
    lo_wr = (which == 0); hi_wr = (which == 1); en_wr = (which == 2);
    @(negedge clk);
    lo_wr = 0; hi_wr = 0; en_wr = 0;
    if (which == 0) m_lo = d[6:0];
    if (which == 1) m_hi = d[6:0];
    if (which == 2) m_en = d[0];
  endtask

  task automatic clear(input logic [7:0] d);
    @(negedge clk);
    cfg_wdata = d; ctrl_wr = 1;
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  // strobe, then sample at the negedge after the capture edge
  task automatic strobe(input logic [6:0] a, input logic rw, input logic with_clr);
    @(negedge clk);
    addr_byte = {a, rw}; addr_stb = 1; ctrl_wr = with_clr;
    @(negedge clk);
    addr_stb = 0; ctrl_wr = 0;
  endtask

  task automatic probe(string req, logic [6:0] a);
    logic e;
    clear(8'hA5);
    e = model(a);
    strobe(a, 1'b0, 1'b0);
    chk(req, $sformatf("flag addr %h", a), rng_flag, e);
    chk(req, $sformatf("pulse addr %h", a), match_pulse, e);
    @(negedge clk);
    chk("R9", "pulse width", match_pulse, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1", "flag reset", rng_flag, 1'b0);
    chk("R1", "dir reset", slv_dir, 1'b0);
    chk("R1", "pulse reset", match_pulse, 1'b0);
    strobe(7'h00, 1'b1, 1'b0);   // regs reset to 0 -> no hit even for 0
    chk("R1", "no hit with reset regs", match_pulse, 1'b0);
  endtask

  task automatic t_disabled;
    wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h00);
    probe("R2", 7'h18);
    probe("R2", 7'h20);
  endtask

  task automatic t_window;
    wr(2, 8'h01);                 // R11 enable load
    probe("R4", 7'h10);
    probe("R4", 7'h11);
    probe("R4", 7'h18);
    probe("R4", 7'h20);
    probe("R4", 7'h21);
    wr(0, 8'h30);                 // R11 lower-bound load moves window
    probe("R11", 7'h18);
  endtask

  task automatic t_exact;
    wr(0, 8'h50); wr(1, 8'h30);
    probe("R3", 7'h30);
    probe("R3", 7'h40);
    probe("R3", 7'h55);
    wr(1, 8'h3F);                 // R11 upper load
    probe("R11", 7'h3F);
  endtask

  task automatic t_gencall;
    wr(0, 8'h00); wr(1, 8'h00);
    probe("R5", 7'h00);
    wr(1, 8'h7F);
    probe("R5", 7'h00);
  endtask

  task automatic t_clear_collide;
    wr(0, 8'h10); wr(1, 8'h20);
    strobe(7'h15, 1'b0, 1'b0);
    chk("R6", "flag set before clear", rng_flag, 1'b1);
    clear(8'h00);
    chk("R6", "cleared with data 00", rng_flag, 1'b0);
    strobe(7'h15, 1'b0, 1'b0);
    clear(8'hFF);
    chk("R6", "cleared with data FF", rng_flag, 1'b0);
    strobe(7'h15, 1'b0, 1'b1);
    chk("R7", "set wins over clear", rng_flag, 1'b1);
    strobe(7'h40, 1'b0, 1'b1);
    chk("R6", "miss plus clear clears", rng_flag, 1'b0);
  endtask

  task automatic t_dir_sticky;
    strobe(7'h12, 1'b1, 1'b0);
    chk("R8", "dir read", slv_dir, 1'b1);
    strobe(7'h60, 1'b0, 1'b0);
    chk("R8", "dir held on miss", slv_dir, 1'b1);
    chk("R10", "flag held on miss", rng_flag, 1'b1);
    chk("R9", "no pulse on miss", match_pulse, 1'b0);
    strobe(7'h00, 1'b0, 1'b0);
    chk("R10", "flag held on general call", rng_flag, 1'b1);
    strobe(7'h13, 1'b0, 1'b0);
    chk("R8", "dir write", slv_dir, 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_window;
    t_exact;
    t_gencall;
    t_clear_collide;
    t_dir_sticky;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule